// File: doc/BRIEF.md
# Framed Link Integrity Supervisor

This block sits on the receive side of a serial data link that has crossed an isolation barrier. It watches the incoming bit stream for frame boundaries and checks every frame's CRC. It keeps handing a sample word to the consumer while the link is disturbed. Frames that fail are never passed on as valid: the output repeats the last good value with a hold flag, and the block goes back to hunting for boundaries when disturbances repeat.

Each frame is 40 bits, sent most significant bit first. It carries a 16-bit sync marker, then a 16-bit sample, then an 8-bit CRC of the sample. Bits arrive on the receive clock, qualified by a per-bit enable. If the stream stops while the block is locked, that is a timeout. Losing lock starts a resynchronisation timer. If lock is not back within a configured bound, a sticky fault is raised. Five saturating counters (CRC errors, timeouts, resync events, invalid slots and total slots) let a host work out error rates. A one-cycle clear pulse zeroes the counters and the fault.

Top module: `lnk_integrity_sup`

## Requirements
- R1: A frame is 40 bits received MSB first, one bit per clock with bit_en_i high: sync marker SYNC_WORD (default 16'hE4B1) in bits 39..24, sample in bits 23..8, and CRC in bits 7..0. The CRC is computed over the 16 sample bits with polynomial x^8+x^2+x+1 (0x07) and initial value 0. A frame is good only if both the marker and the CRC match.
- R2: While hunting, a good frame is recognised at any bit offset. That frame sets the alignment. lock_o rises on the clock edge that takes in the last bit of the next consecutive good frame. A bad frame at that point returns the block to hunting.
- R3: The frame that completes locking, and every good frame while locked, produce a one-cycle smp_stb_o. On the following edge, smp_o takes the frame's sample, smp_valid_o goes to 1 and hold_o goes to 0. smp_valid_o and hold_o are never high together.
- R4: A bad frame while locked gives smp_stb_o with smp_valid_o=0 and hold_o=1. smp_o keeps the last good sample, and crc_err_cnt_o increments.
- R5: Three consecutive bad frames while locked drop lock_o and start hunting again, and resync_cnt_o increments. A good frame resets the run of bad frames.
- R6: While locked, if TIMEOUT_CYC clock cycles pass with no frame end, timeout_cnt_o and resync_cnt_o increment. A slot with smp_valid_o=0 and hold_o=1 is emitted, and lock drops. While lock_o is low, smp_valid_o is 0.
- R7: If lock has not been regained RESYNC_MAX cycles after a lock drop, fault_o rises one cycle later. It stays high, even after lock returns, until clr_i.
- R8: total_cnt_o counts every output slot (good, bad or timeout). invalid_cnt_o counts the bad and timeout slots.
- R9: Every counter is CNT_W bits (default 16) and saturates at all-ones instead of wrapping.
- R10: A one-cycle clr_i pulse zeroes all counters and fault_o on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_i | input | 1 | Serial data bit |
| bit_en_i | input | 1 | bit_i carries a new bit this cycle |
| clr_i | input | 1 | Clear counters and fault |
| smp_o | output | SMP_W | Delivered or repeated sample |
| smp_stb_o | output | 1 | One-cycle pulse per output slot |
| smp_valid_o | output | 1 | smp_o holds a freshly received good sample |
| hold_o | output | 1 | smp_o is a repeated last good sample |
| lock_o | output | 1 | Frame alignment locked |
| fault_o | output | 1 | Resync bound exceeded (sticky) |
| crc_err_cnt_o | output | CNT_W | Bad frames while locked |
| timeout_cnt_o | output | CNT_W | Missing-frame timeouts |
| resync_cnt_o | output | CNT_W | Lock drops |
| invalid_cnt_o | output | CNT_W | Invalid output slots |
| total_cnt_o | output | CNT_W | All output slots |

## Verification
The bench checks the following corner cases, each against what a faulty design would show:
- A bad frame wedged between good ones must not count toward the three-failure drop. A design that does not reset the run would drop lock one frame early.
- A corrupted sync marker with a correct CRC must still be treated as bad. A design that checks only the CRC would emit valid data for it.
- A stalled stream must produce a timeout slot and a lock drop, without repeating stale data as valid.
- A long stall must raise the fault and keep it after relock until cleared.
- A narrow counter instance, driven past its top, must stick at all-ones. A wrapping counter would show a small value.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  typedef enum logic [1:0] {ST_HUNT = 2'd0, ST_VERIFY = 2'd1, ST_LOCK = 2'd2} lnk_st_e;
  localparam int CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam int NUM_CNT = 5;
  localparam int CI_CRC = 0;
  localparam int CI_TMO = 1;
  localparam int CI_RSY = 2;
  localparam int CI_INV = 3;
  localparam int CI_TOT = 4;
endpackage

// File: rtl/lnk_framer.sv
module lnk_framer import lnk_pkg::*; #(
  parameter int SYNC_W = 16,
  parameter int SMP_W = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hE4B1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_en_i,
  input  logic             hunt_i,
  output logic             frm_end_o,
  output logic             frm_good_o,
  output logic [SMP_W-1:0] frm_data_o
);
  localparam int FRM_W = SYNC_W + SMP_W + CRC_W;
  localparam int POS_W = $clog2(FRM_W);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRM_W - 1);

  logic [FRM_W-1:0] win_q, win_nx;
  logic [POS_W-1:0] pos_q;
  logic [CRC_W-1:0] crc_c;
  logic             fb;

  assign win_nx     = {win_q[FRM_W-2:0], bit_i};
  assign frm_data_o = win_nx[CRC_W +: SMP_W];

  // serial CRC over the sample field, MSB first
  always_comb begin
    crc_c = '0;
    fb    = 1'b0;
    for (int i = SMP_W - 1; i >= 0; i--) begin
      fb    = crc_c[CRC_W-1] ^ frm_data_o[i];
      crc_c = {crc_c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
  end

  assign frm_good_o = (win_nx[FRM_W-1 -: SYNC_W] == SYNC_WORD) &&
                      (crc_c == win_nx[CRC_W-1:0]);
  // hunting: every bit is a candidate boundary; tracking: every FRM_W bits
  assign frm_end_o  = bit_en_i && (hunt_i ? frm_good_o : (pos_q == POS_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      pos_q <= '0;
    end else if (bit_en_i) begin
      win_q <= win_nx;
      pos_q <= (hunt_i || frm_end_o) ? '0 : pos_q + 1'b1;
    end
  end

  always_comb begin
    if (rst_ni) p_pos_range_r1: assert (pos_q <= POS_LAST);
  end

  p_track_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !hunt_i && pos_q != POS_LAST) |-> !frm_end_o);
endmodule

// File: rtl/lnk_sat_cnt.sv
module lnk_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (inc_i && ~&cnt_q)     cnt_q <= cnt_q + 1'b1;
  end

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cnt_q && !clr_i) |=> &cnt_q);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/lnk_sup_fsm.sv
module lnk_sup_fsm import lnk_pkg::*; #(
  parameter int SMP_W = 16,
  parameter int TIMEOUT_CYC = 100,
  parameter int RESYNC_MAX = 300,
  parameter int LOCK_GOOD = 2,
  parameter int DROP_BAD = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               frm_end_i,
  input  logic               frm_good_i,
  input  logic [SMP_W-1:0]   frm_data_i,
  output logic               hunt_o,
  output logic               lock_o,
  output logic               fault_o,
  output logic [SMP_W-1:0]   smp_o,
  output logic               smp_stb_o,
  output logic               smp_valid_o,
  output logic               hold_o,
  output logic [NUM_CNT-1:0] inc_o
);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int RS_W  = $clog2(RESYNC_MAX + 1);
  localparam int GR_W  = $clog2(LOCK_GOOD + 1);
  localparam int BR_W  = $clog2(DROP_BAD + 1);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYC - 1);
  localparam logic [RS_W-1:0] RS_LIM  = RS_W'(RESYNC_MAX);
  localparam logic [GR_W-1:0] GR_LAST = GR_W'(LOCK_GOOD - 1);
  localparam logic [BR_W-1:0] BR_LAST = BR_W'(DROP_BAD - 1);

  lnk_st_e          st_q;
  logic [GR_W-1:0]  good_run_q;
  logic [BR_W-1:0]  bad_run_q;
  logic [TO_W-1:0]  to_tmr_q;
  logic [RS_W-1:0]  rs_tmr_q;
  logic             rs_busy_q, fault_q;
  logic [SMP_W-1:0] smp_q;
  logic             stb_q, valid_q, hold_q;
  logic             timeout, ev_good, ev_bad, verify_ok, drop, deliver;

  assign timeout   = (st_q == ST_LOCK) && !frm_end_i && (to_tmr_q == TO_LAST);
  assign ev_good   = (st_q == ST_LOCK) && frm_end_i && frm_good_i;
  assign ev_bad    = (st_q == ST_LOCK) && frm_end_i && !frm_good_i;
  assign verify_ok = (st_q == ST_VERIFY) && frm_end_i && frm_good_i && (good_run_q == GR_LAST);
  assign drop      = timeout || (ev_bad && bad_run_q == BR_LAST);
  assign deliver   = ev_good || verify_ok;

  always_comb begin
    inc_o         = '0;
    inc_o[CI_CRC] = ev_bad;
    inc_o[CI_TMO] = timeout;
    inc_o[CI_RSY] = drop;
    inc_o[CI_INV] = ev_bad || timeout;
    inc_o[CI_TOT] = deliver || ev_bad || timeout;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_HUNT;
      good_run_q <= '0;
      bad_run_q  <= '0;
    end else begin
      unique case (st_q)
        ST_HUNT: if (frm_end_i) begin
          st_q       <= ST_VERIFY;
          good_run_q <= GR_W'(1);
        end
        ST_VERIFY: if (frm_end_i) begin
          if (!frm_good_i) st_q <= ST_HUNT;
          else if (verify_ok) begin
            st_q      <= ST_LOCK;
            bad_run_q <= '0;
          end else good_run_q <= good_run_q + 1'b1;
        end
        ST_LOCK: begin
          if (drop)           st_q      <= ST_HUNT;
          else if (ev_good)   bad_run_q <= '0;
          else if (ev_bad)    bad_run_q <= bad_run_q + 1'b1;
        end
        default: st_q <= ST_HUNT;
      endcase
    end
  end

  // missing-frame watchdog and resync bound
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_tmr_q  <= '0;
      rs_tmr_q  <= '0;
      rs_busy_q <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      to_tmr_q <= (st_q != ST_LOCK || frm_end_i) ? '0 : to_tmr_q + 1'b1;
      if (drop) begin
        rs_busy_q <= 1'b1;
        rs_tmr_q  <= '0;
      end else if (verify_ok) begin
        rs_busy_q <= 1'b0;
      end else if (rs_busy_q && rs_tmr_q != RS_LIM) begin
        rs_tmr_q <= rs_tmr_q + 1'b1;
      end
      if (clr_i)                                fault_q <= 1'b0;
      else if (rs_busy_q && rs_tmr_q == RS_LIM) fault_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q   <= '0;
      stb_q   <= 1'b0;
      valid_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      stb_q <= inc_o[CI_TOT];
      if (deliver) begin
        smp_q   <= frm_data_i;
        valid_q <= 1'b1;
        hold_q  <= 1'b0;
      end else if (ev_bad || timeout) begin
        valid_q <= 1'b0;
        hold_q  <= 1'b1;
      end
    end
  end

  assign hunt_o      = (st_q == ST_HUNT);
  assign lock_o      = (st_q == ST_LOCK);
  assign fault_o     = fault_q;
  assign smp_o       = smp_q;
  assign smp_stb_o   = stb_q;
  assign smp_valid_o = valid_q;
  assign hold_o      = hold_q;

  p_valid_hold_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_q && hold_q));
  p_hold_keeps_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_bad && !drop) |=> (hold_q && $stable(smp_q) && lock_o));
  p_drop_third_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && frm_end_i && !frm_good_i && bad_run_q == BR_LAST) |=> hunt_o);
  p_timeout_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout |=> (!lock_o && !valid_q && hold_q && stb_q));
  p_no_valid_unlocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> !valid_q);
  p_fault_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_busy_q && rs_tmr_q == RS_LIM && !clr_i) |=> fault_q);
  p_fault_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !clr_i) |=> fault_q);
endmodule

// File: rtl/lnk_integrity_sup.sv
module lnk_integrity_sup import lnk_pkg::*; #(
  parameter int SYNC_W = 16,
  parameter int SMP_W = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hE4B1,
  parameter int CNT_W = 16,
  parameter int TIMEOUT_CYC = 100,
  parameter int RESYNC_MAX = 300
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             bit_en_i,
  input  logic             clr_i,
  output logic [SMP_W-1:0] smp_o,
  output logic             smp_stb_o,
  output logic             smp_valid_o,
  output logic             hold_o,
  output logic             lock_o,
  output logic             fault_o,
  output logic [CNT_W-1:0] crc_err_cnt_o,
  output logic [CNT_W-1:0] timeout_cnt_o,
  output logic [CNT_W-1:0] resync_cnt_o,
  output logic [CNT_W-1:0] invalid_cnt_o,
  output logic [CNT_W-1:0] total_cnt_o
);
  logic             hunt, frm_end, frm_good;
  logic [SMP_W-1:0] frm_data;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0] cnt_w [NUM_CNT];

  lnk_framer #(.SYNC_W(SYNC_W), .SMP_W(SMP_W), .SYNC_WORD(SYNC_WORD)) u_framer (
    .clk_i, .rst_ni, .bit_i, .bit_en_i,
    .hunt_i(hunt), .frm_end_o(frm_end), .frm_good_o(frm_good), .frm_data_o(frm_data)
  );

  lnk_sup_fsm #(.SMP_W(SMP_W), .TIMEOUT_CYC(TIMEOUT_CYC), .RESYNC_MAX(RESYNC_MAX)) u_fsm (
    .clk_i, .rst_ni, .clr_i,
    .frm_end_i(frm_end), .frm_good_i(frm_good), .frm_data_i(frm_data),
    .hunt_o(hunt), .lock_o, .fault_o, .smp_o, .smp_stb_o, .smp_valid_o, .hold_o,
    .inc_o(inc)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    lnk_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni, .clr_i, .inc_i(inc[g]), .cnt_o(cnt_w[g])
    );
  end

  assign crc_err_cnt_o = cnt_w[CI_CRC];
  assign timeout_cnt_o = cnt_w[CI_TMO];
  assign resync_cnt_o  = cnt_w[CI_RSY];
  assign invalid_cnt_o = cnt_w[CI_INV];
  assign total_cnt_o   = cnt_w[CI_TOT];
endmodule

// File: tb/lnk_integrity_sup_tb_top.sv
module lnk_integrity_sup_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TO_CYC = 100;
  localparam int RS_MAX = 300;
  localparam logic [15:0] SYNC = 16'hE4B1;
  localparam int NVEC = 11;
  // {sample, kind(0 good,1 bad crc,2 bad sync), lock, valid, hold, stb, 2'b0, exp smp}
  localparam logic [39:0] VEC [NVEC] = '{
    {16'h1234, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b0, 16'h0000},
    {16'h1234, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'h1234},
    {16'hBEEF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'hBEEF},
    {16'h0F0F, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b0, 16'hBEEF},
    {16'h8001, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'h8001},
    {16'h7777, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 2'b0, 16'h8001},
    {16'h0F0F, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 2'b0, 16'h8001},
    {16'h0F0F, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b0, 16'h8001},
    {16'h00FF, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b0, 16'h8001},
    {16'hFFFF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'hFFFF},
    {16'h0000, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b0, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, bit_v = 1'b0, bit_en = 1'b0, clr = 1'b0;
  logic [15:0] smp;
  logic stb, valid, hold, lock, fault;
  logic [15:0] c_crc, c_tmo, c_rsy, c_inv, c_tot;
  logic [15:0] s_smp;
  logic s_stb, s_valid, s_hold, s_lock, s_fault;
  logic [2:0] s_crc, s_tmo, s_rsy, s_inv, s_tot;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_integrity_sup #(.TIMEOUT_CYC(TO_CYC), .RESYNC_MAX(RS_MAX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_v), .bit_en_i(bit_en), .clr_i(clr),
    .smp_o(smp), .smp_stb_o(stb), .smp_valid_o(valid), .hold_o(hold), .lock_o(lock),
    .fault_o(fault), .crc_err_cnt_o(c_crc), .timeout_cnt_o(c_tmo), .resync_cnt_o(c_rsy),
    .invalid_cnt_o(c_inv), .total_cnt_o(c_tot)
  );

  lnk_integrity_sup #(.CNT_W(3), .TIMEOUT_CYC(TO_CYC), .RESYNC_MAX(RS_MAX)) dut_sat_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_v), .bit_en_i(bit_en), .clr_i(clr),
    .smp_o(s_smp), .smp_stb_o(s_stb), .smp_valid_o(s_valid), .hold_o(s_hold), .lock_o(s_lock),
    .fault_o(s_fault), .crc_err_cnt_o(s_crc), .timeout_cnt_o(s_tmo), .resync_cnt_o(s_rsy),
    .invalid_cnt_o(s_inv), .total_cnt_o(s_tot)
  );

  // CRC by long division of {data, 8'b0} by 9'h107
  function automatic logic [7:0] ref_crc(input logic [15:0] d);
    logic [23:0] r = {d, 8'h00};
    for (int i = 23; i >= 8; i--)
      if (r[i]) r[i -: 9] = r[i -: 9] ^ 9'h107;
    return r[7:0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts and ends at a negedge; bits are contiguous across calls
  task automatic send_frame(input logic [15:0] s, input logic [1:0] kind);
    logic [39:0] f;
    f = {SYNC ^ ((kind == 2'd2) ? 16'h0100 : 16'h0000), s,
         ref_crc(s) ^ ((kind == 2'd1) ? 8'h01 : 8'h00)};
    for (int b = 39; b >= 0; b--) begin
      bit_v  = f[b];
      bit_en = 1'b1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3 reset valid", valid, 0);
    chk("R3 reset hold", hold, 0);
    chk("R2 reset lock", lock, 0);
    chk("R7 reset fault", fault, 0);
    chk("R8 reset total", c_tot, 0);

    // table: R1 framing, R2 lock, R3 delivery, R4 bad frame, R5 drop
    for (int i = 0; i < NVEC; i++) begin
      send_frame(VEC[i][39:24], VEC[i][23:22]);
      chk($sformatf("R2 lock v%0d", i),  lock,  VEC[i][21]);
      chk($sformatf("R3 valid v%0d", i), valid, VEC[i][20]);
      chk($sformatf("R4 hold v%0d", i),  hold,  VEC[i][19]);
      chk($sformatf("R3 stb v%0d", i),   stb,   VEC[i][18]);
      chk($sformatf("R4 smp v%0d", i),   smp,   VEC[i][15:0]);
    end
    chk("R4 crc_err count", c_crc, 4);
    chk("R5 resync count", c_rsy, 1);
    chk("R8 total count", c_tot, 9);
    chk("R8 invalid count", c_inv, 4);
    chk("R7 no fault after quick relock", fault, 0);

    // R6 stall: no timeout before the interval, timeout after
    bit_en = 1'b0;
    repeat (TO_CYC - 10) @(negedge clk);
    chk("R6 still locked before interval", lock, 1);
    repeat (15) @(negedge clk);
    chk("R6 timeout count", c_tmo, 1);
    chk("R6 resync count", c_rsy, 2);
    chk("R6 lock dropped", lock, 0);
    chk("R6 not valid", valid, 0);
    chk("R6 hold", hold, 1);
    chk("R6 smp kept", smp, 16'h0000);
    chk("R8 invalid after timeout", c_inv, 5);
    chk("R7 no fault yet", fault, 0);

    // R7 exceed resync bound
    repeat (RS_MAX + 5) @(negedge clk);
    chk("R7 fault raised", fault, 1);
    send_frame(16'h4321, 2'd0);
    chk("R2 verify not locked", lock, 0);
    send_frame(16'h4321, 2'd0);
    bit_en = 1'b0;
    chk("R2 relocked", lock, 1);
    chk("R3 relock sample", smp, 16'h4321);
    chk("R7 fault sticky", fault, 1);

    // R10 clear
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R10 fault cleared", fault, 0);
    chk("R10 crc cleared", c_crc, 0);
    chk("R10 total cleared", c_tot, 0);
    chk("R10 resync cleared", c_rsy, 0);

    // R9 saturation, R5 run reset by good frame
    for (int k = 0; k < 4; k++) begin
      send_frame(16'h5A5A, 2'd1);
      send_frame(16'h5A5A, 2'd1);
      send_frame(16'h1357 + 16'(k), 2'd0);
      chk("R5 lock kept after two bad", lock, 1);
    end
    bit_en = 1'b0;
    chk("R9 wide crc count", c_crc, 8);
    chk("R9 wide total count", c_tot, 12);
    chk("R9 narrow crc saturates", s_crc, 7);
    chk("R9 narrow total saturates", s_tot, 7);
    chk("R3 final sample", smp, 16'h135A);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule